// File: doc/BRIEF.md
# Memory Error Interrupt Controller

This block gathers error events reported by a memory controller and presents them to a host as sticky cause bits, gated by an enable mask. It receives single-cycle pulses for four kinds of fault: a correctable ECC error, an uncorrectable ECC error, a multi-bit parity field, and an address error. It drives a level interrupt towards a chip-level interrupt aggregator, together with a separate fatal flag. For the two ECC classes it keeps its own snapshot of the failing address and the data words that came with the event. The ECC decoder that produces these pulses and the aggregator that consumes the interrupt lie outside the block.

Software reaches the state through a small word-indexed register port. Reads return data one cycle after the request. Cause bits are cleared by writing ones to them. A summary bit mirrors the pending interrupt and needs its own write-one-to-clear. A compatibility strap selects a second clearing scheme. In that scheme, ones written to the enable register clear the matching cause bits, and software then writes the mask back.

Top module: `mem_err_irq`

## Requirements
- R1: After reset, the cause, enable, summary and both capture sets read as zero, and `irq_o` and `fatal_o` are low.
- R2: Cause layout (register index 0): bit 0 is correctable, bit 1 is uncorrectable, bits 2..2+PW-1 are parity (one bit per `par_evt_i` lane), and bit 2+PW is address error. An event pulse sets its bit in the next cycle, and the bit stays set until it is cleared.
- R3: `irq_o` is high exactly while some cause bit and its matching bit in the enable register (index 1, same layout) are both set. An all-zero enable keeps `irq_o` low.
- R4: `fatal_o` is high while any uncorrectable, parity or address-error cause bit is set, whatever the enable mask holds. The correctable bit alone never raises it.
- R5: With `clr_by_en_i` low, a write to index 0 clears exactly the cause bits where the write data holds a one. Each parity bit clears on its own.
- R6: An event that arrives in the same cycle as a clear of its bit wins, and the bit stays set.
- R7: A correctable event that arrives while cause bit 0 is clear stores `cap_addr_i` at index 3 and the data words at indices 4..3+NW. An uncorrectable event stores them at index 4+NW and at indices 5+NW..4+2NW. Data word j is `cap_data_i[j*DW +: DW]`.
- R8: A capture set holds the first error of its class until that class's cause bit is cleared. Later events of the same class do not change it.
- R9: Summary bit 0 (index 2) is set one cycle after an enabled cause bit is pending. A write with bit 0 set clears it, but it sets again while an enabled cause is still pending.
- R10: With `clr_by_en_i` high, a write to the enable register clears the cause bits where the write data holds a one and loads the data as the new mask. Writes to index 0 have no effect in this mode.
- R11: Read data appears on `reg_rdata_o` in the cycle after the read request. Unmapped indices read zero. Writes to capture registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_by_en_i | input | 1 | Compatibility clear mode select |
| ce_evt_i | input | 1 | Correctable error pulse |
| ue_evt_i | input | 1 | Uncorrectable error pulse |
| par_evt_i | input | PW | Parity error lanes |
| addr_evt_i | input | 1 | Address error pulse |
| cap_addr_i | input | CAP_AW | Failing address that accompanies an ECC event |
| cap_data_i | input | NW*DW | Failing data words, packed |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | Access is a write |
| reg_addr_i | input | RAW | Register word index |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, one cycle after the request |
| irq_o | output | 1 | Level interrupt |
| fatal_o | output | 1 | Fatal error flag |

## Verification
The assertions assume that event inputs are pulses sampled on clock edges. They also assume `clr_by_en_i` is a strap that changes only while the register port is idle, and that capture inputs are valid in the cycle their event is high. The bench drives all inputs on the falling edge and pulses each event for exactly one cycle. It changes the mode strap only between tasks, with no access in flight. Address and data patterns differ for each event, so a capture overwritten by a later event shows up in the read-back.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;
  localparam int unsigned IDX_CAUSE   = 0;
  localparam int unsigned IDX_ENABLE  = 1;
  localparam int unsigned IDX_SUMMARY = 2;
  localparam int unsigned IDX_CE_ADDR = 3;

  function automatic int unsigned cause_width(int unsigned pw);
    return pw + 3;
  endfunction

  // first index of a capture set: class 0 correctable, class 1 uncorrectable
  function automatic int unsigned cap_base(int unsigned cls, int unsigned nw);
    return IDX_CE_ADDR + cls * (nw + 1);
  endfunction

  function automatic int unsigned last_index(int unsigned nw);
    return IDX_CE_ADDR + 2 * (nw + 1) - 1;
  endfunction
endpackage

// File: rtl/mem_err_cause.sv
module mem_err_cause #(
  parameter int PW = 4,
  parameter int DW = 32,
  localparam int CW = PW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_by_en_i,
  input  logic [CW-1:0] evt_i,
  input  logic          cause_wr_i,
  input  logic          enable_wr_i,
  input  logic          summary_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cause_o,
  output logic [CW-1:0] enable_o,
  output logic          summary_o,
  output logic          irq_o,
  output logic          fatal_o
);
  localparam logic [CW-1:0] FATAL_MASK = ~CW'(1);

  logic [CW-1:0] cause_q, enable_q, clr_vec, keep_vec;
  logic          sum_q, pend;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:CW];

  always_comb begin
    clr_vec = '0;
    if (!clr_by_en_i && cause_wr_i)  clr_vec = wdata_i[CW-1:0];
    if (clr_by_en_i  && enable_wr_i) clr_vec = wdata_i[CW-1:0];
  end

  assign keep_vec = cause_q & ~clr_vec;
  assign pend     = |(cause_q & enable_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q  <= '0;
      enable_q <= '0;
      sum_q    <= 1'b0;
    end else begin
      cause_q <= keep_vec | evt_i;
      if (enable_wr_i) enable_q <= wdata_i[CW-1:0];
      sum_q <= (sum_q & ~(summary_wr_i & wdata_i[0])) | pend;
    end
  end

  assign cause_o   = cause_q;
  assign enable_o  = enable_q;
  assign summary_o = sum_q;
  assign irq_o     = pend;
  assign fatal_o   = |(cause_q & FATAL_MASK);

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q & $past(keep_vec)) == $past(keep_vec)));
  // R6
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));
  // R4
  ce_not_fatal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q == CW'(1)) |-> !fatal_o);
  // R9
  summary_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> summary_o);
  // R10
  compat_cause_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_by_en_i && cause_wr_i && !enable_wr_i)
      |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture #(
  parameter int CAP_AW = 28,
  parameter int DW     = 32,
  parameter int NW     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CAP_AW-1:0] addr_i,
  input  logic [NW*DW-1:0] data_i,
  output logic [CAP_AW-1:0] addr_o,
  output logic [NW*DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (take_i) addr_o <= addr_i;
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     data_o[w*DW +: DW] <= '0;
      else if (take_i) data_o[w*DW +: DW] <= data_i[w*DW +: DW];
    end
  end
endmodule

// File: rtl/mem_err_regif.sv
module mem_err_regif
  import mem_err_pkg::*;
#(
  parameter int DW     = 32,
  parameter int RAW    = 4,
  parameter int CW     = 7,
  parameter int NW     = 5,
  parameter int CAP_AW = 28
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_valid_i,
  input  logic                        reg_write_i,
  input  logic [RAW-1:0]              reg_addr_i,
  input  logic [CW-1:0]               cause_i,
  input  logic [CW-1:0]               enable_i,
  input  logic                        summary_i,
  input  logic [1:0][CAP_AW-1:0]      cap_addr_i,
  input  logic [1:0][NW*DW-1:0]       cap_data_i,
  output logic                        cause_wr_o,
  output logic                        enable_wr_o,
  output logic                        summary_wr_o,
  output logic [DW-1:0]               reg_rdata_o
);
  localparam int LAST = int'(last_index(NW));

  logic          wr, rd;
  int            idx;
  logic [DW-1:0] rd_mux, rdata_q;

  assign wr  = reg_valid_i & reg_write_i;
  assign rd  = reg_valid_i & ~reg_write_i;
  assign idx = int'(reg_addr_i);

  assign cause_wr_o   = wr && (idx == int'(IDX_CAUSE));
  assign enable_wr_o  = wr && (idx == int'(IDX_ENABLE));
  assign summary_wr_o = wr && (idx == int'(IDX_SUMMARY));

  always_comb begin
    rd_mux = '0;
    if (idx == int'(IDX_CAUSE))   rd_mux[CW-1:0] = cause_i;
    if (idx == int'(IDX_ENABLE))  rd_mux[CW-1:0] = enable_i;
    if (idx == int'(IDX_SUMMARY)) rd_mux[0]      = summary_i;
    for (int c = 0; c < 2; c++) begin
      if (idx == int'(cap_base(c, NW))) rd_mux[CAP_AW-1:0] = cap_addr_i[c];
      for (int j = 0; j < NW; j++)
        if (idx == int'(cap_base(c, NW)) + 1 + j) rd_mux = cap_data_i[c][j*DW +: DW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;

  // R11
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && idx > LAST) |=> (reg_rdata_o == '0));
endmodule

// File: rtl/mem_err_irq.sv
module mem_err_irq
  import mem_err_pkg::*;
#(
  parameter int PW     = 4,
  parameter int DW     = 32,
  parameter int NW     = 5,
  parameter int CAP_AW = 28,
  localparam int RAW   = $clog2(int'(last_index(NW)) + 2),
  localparam int CW    = PW + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_by_en_i,
  input  logic              ce_evt_i,
  input  logic              ue_evt_i,
  input  logic [PW-1:0]     par_evt_i,
  input  logic              addr_evt_i,
  input  logic [CAP_AW-1:0] cap_addr_i,
  input  logic [NW*DW-1:0]  cap_data_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [RAW-1:0]    reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o,
  output logic              fatal_o
);
  logic [CW-1:0]          evt_vec, cause, enable;
  logic                   summary, cause_wr, enable_wr, summary_wr;
  logic [1:0]             take;
  logic [1:0][CAP_AW-1:0] cap_addr;
  logic [1:0][NW*DW-1:0]  cap_data;

  assign evt_vec = {addr_evt_i, par_evt_i, ue_evt_i, ce_evt_i};

  mem_err_cause #(.PW(PW), .DW(DW)) u_cause (
    .clk_i, .rst_ni, .clr_by_en_i,
    .evt_i        (evt_vec),
    .cause_wr_i   (cause_wr),
    .enable_wr_i  (enable_wr),
    .summary_wr_i (summary_wr),
    .wdata_i      (reg_wdata_i),
    .cause_o      (cause),
    .enable_o     (enable),
    .summary_o    (summary),
    .irq_o,
    .fatal_o
  );

  // class 0 = correctable, class 1 = uncorrectable; cause bit index equals class
  for (genvar c = 0; c < 2; c++) begin : g_cap
    assign take[c] = evt_vec[c] & ~cause[c];
    mem_err_capture #(.CAP_AW(CAP_AW), .DW(DW), .NW(NW)) u_cap (
      .clk_i, .rst_ni,
      .take_i (take[c]),
      .addr_i (cap_addr_i),
      .data_i (cap_data_i),
      .addr_o (cap_addr[c]),
      .data_o (cap_data[c])
    );
  end

  mem_err_regif #(.DW(DW), .RAW(RAW), .CW(CW), .NW(NW), .CAP_AW(CAP_AW)) u_regif (
    .clk_i, .rst_ni, .reg_valid_i, .reg_write_i, .reg_addr_i,
    .cause_i      (cause),
    .enable_i     (enable),
    .summary_i    (summary),
    .cap_addr_i   (cap_addr),
    .cap_data_i   (cap_data),
    .cause_wr_o   (cause_wr),
    .enable_wr_o  (enable_wr),
    .summary_wr_o (summary_wr),
    .reg_rdata_o
  );

  // R7
  ce_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_evt_i && !cause[0]) |=> (cap_addr[0] == $past(cap_addr_i)));
  // R8
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause[0] |=> ($stable(cap_addr[0]) && $stable(cap_data[0])));
  // R8
  ue_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause[1] |=> ($stable(cap_addr[1]) && $stable(cap_data[1])));
endmodule

// File: tb/mem_err_irq_tb.sv
module mem_err_irq_tb;
  localparam int PW = 4, DW = 32, NW = 5, CAP_AW = 28, RAW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_by_en_i = 1'b0;
  logic ce_evt_i = 0, ue_evt_i = 0, addr_evt_i = 0;
  logic [PW-1:0] par_evt_i = '0;
  logic [CAP_AW-1:0] cap_addr_i = '0;
  logic [NW*DW-1:0] cap_data_i = '0;
  logic reg_valid_i = 0, reg_write_i = 0;
  logic [RAW-1:0] reg_addr_i = '0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic irq_o, fatal_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  mem_err_irq #(.PW(PW), .DW(DW), .NW(NW), .CAP_AW(CAP_AW)) u_dut (.*);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int a, logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1; reg_write_i = 1; reg_addr_i = RAW'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_valid_i = 0; reg_write_i = 0;
  endtask

  task automatic reg_rd(int a, output logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1; reg_write_i = 0; reg_addr_i = RAW'(a);
    @(negedge clk_i);
    d = reg_rdata_o;
    reg_valid_i = 0;
  endtask

  task automatic expect_reg(int a, logic [31:0] exp, string req);
    logic [31:0] d;
    reg_rd(a, d);
    check(d === exp, req, d, exp);
  endtask

  function automatic logic [31:0] word(logic [31:0] base, int j);
    return base + 32'h1111 * j;
  endfunction

  task automatic pulse(logic ce, logic ue, logic [PW-1:0] par, logic ad,
                       logic [31:0] base);
    @(negedge clk_i);
    ce_evt_i = ce; ue_evt_i = ue; par_evt_i = par; addr_evt_i = ad;
    cap_addr_i = CAP_AW'(base >> 4);
    for (int j = 0; j < NW; j++) cap_data_i[j*DW +: DW] = word(base, j);
    @(negedge clk_i);
    ce_evt_i = 0; ue_evt_i = 0; par_evt_i = '0; addr_evt_i = 0;
  endtask

  task automatic expect_cap(int cls, logic [31:0] base, string req);
    int b = 3 + cls * (NW + 1);
    expect_reg(b, 32'(CAP_AW'(base >> 4)), req);
    for (int j = 0; j < NW; j++) expect_reg(b + 1 + j, word(base, j), req);
  endtask

  task automatic t_reset;
    check(irq_o === 0, "R1 irq", 32'(irq_o), 0);
    check(fatal_o === 0, "R1 fatal", 32'(fatal_o), 0);
    expect_reg(0, 0, "R1 cause");
    expect_reg(1, 0, "R1 enable");
    expect_reg(2, 0, "R1 summary");
    expect_reg(3, 0, "R1 ce_addr");
    expect_reg(9, 0, "R1 ue_addr");
  endtask

  task automatic t_correctable;
    pulse(1, 0, '0, 0, 32'hA000_0010);
    expect_reg(0, 32'h1, "R2 ce bit");
    check(irq_o === 0, "R3 masked", 32'(irq_o), 0);
    check(fatal_o === 0, "R4 ce not fatal", 32'(fatal_o), 0);
    reg_wr(1, 32'h7F);
    check(irq_o === 1, "R3 enabled", 32'(irq_o), 1);
    reg_wr(1, 32'h0);
    check(irq_o === 0, "R3 zero mask", 32'(irq_o), 0);
    expect_cap(0, 32'hA000_0010, "R7 ce capture");
    pulse(1, 0, '0, 0, 32'hB000_0020);
    expect_cap(0, 32'hA000_0010, "R8 ce held");
    reg_wr(0, 32'h1);
    expect_reg(0, 32'h0, "R5 ce clear");
    pulse(1, 0, '0, 0, 32'hC000_0030);
    expect_cap(0, 32'hC000_0030, "R8 ce recapture");
    reg_wr(0, 32'h1);
  endtask

  task automatic t_fatal;
    pulse(0, 1, '0, 0, 32'hD000_0040);
    check(fatal_o === 1, "R4 ue fatal", 32'(fatal_o), 1);
    expect_cap(1, 32'hD000_0040, "R7 ue capture");
    pulse(0, 1, '0, 0, 32'hE000_0050);
    expect_cap(1, 32'hD000_0040, "R8 ue held");
    pulse(0, 0, 4'b0101, 0, 32'h0);
    expect_reg(0, 32'h16, "R2 parity bits");
    reg_wr(0, 32'h04);
    expect_reg(0, 32'h12, "R5 parity independent");
    reg_wr(0, 32'h7F);
    check(fatal_o === 0, "R4 cleared", 32'(fatal_o), 0);
    pulse(0, 0, '0, 1, 32'h0);
    expect_reg(0, 32'h40, "R2 addr bit");
    check(fatal_o === 1, "R4 addr fatal", 32'(fatal_o), 1);
  endtask

  task automatic t_collision;
    @(negedge clk_i);
    addr_evt_i = 1;
    reg_valid_i = 1; reg_write_i = 1; reg_addr_i = 0; reg_wdata_i = 32'h40;
    @(negedge clk_i);
    addr_evt_i = 0; reg_valid_i = 0; reg_write_i = 0;
    expect_reg(0, 32'h40, "R6 event wins");
    reg_wr(0, 32'h40);
    expect_reg(0, 32'h0, "R5 addr clear");
  endtask

  task automatic t_summary;
    reg_wr(2, 32'h1);
    expect_reg(2, 32'h0, "R9 summary cleared");
    reg_wr(1, 32'h01);
    pulse(1, 0, '0, 0, 32'hF000_0060);
    expect_reg(2, 32'h1, "R9 summary set");
    reg_wr(2, 32'h1);
    expect_reg(2, 32'h1, "R9 summary re-set");
    reg_wr(0, 32'h1);
    reg_wr(2, 32'h1);
    expect_reg(2, 32'h0, "R9 summary clear");
    reg_wr(1, 32'h0);
  endtask

  task automatic t_compat;
    @(negedge clk_i);
    clr_by_en_i = 1;
    pulse(0, 1, '0, 0, 32'h1200_0070);
    reg_wr(0, 32'h7F);
    expect_reg(0, 32'h2, "R10 cause write ignored");
    reg_wr(1, 32'h02);
    expect_reg(0, 32'h0, "R10 enable write clears");
    expect_reg(1, 32'h2, "R10 enable loaded");
    reg_wr(1, 32'h0);
    @(negedge clk_i);
    clr_by_en_i = 0;
  endtask

  task automatic t_regs;
    expect_reg(15, 32'h0, "R11 unmapped");
    reg_wr(3, 32'hFFFF_FFFF);
    expect_reg(3, 32'(CAP_AW'(32'hF000_0060 >> 4)), "R11 capture read-only");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_correctable();
    t_fatal();
    t_collision();
    t_summary();
    t_compat();
    t_regs();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule